// File: doc/BRIEF.md
# Background Divider with Result Interlock

This block runs an unsigned 32-by-16 division. A divide takes the issuing pipeline slot for only four cycles. During that time the unit decides whether the operation overflows and whether the quotient will be zero, and it publishes both flags when the fourth cycle ends. Code that branches on those flags can therefore continue immediately. The quotient and remainder are then computed in the background over seventeen more cycles. The quotient is written to the low result register and the remainder to the high one.

While the background phase runs, the block acts as a scoreboard. Any request that touches the unit drives a stall request for as long as the divide is still working: a read of either result register, a write to either one, or a new start. Once the results are committed the stall drops, and the waiting request proceeds in the next cycle. When no divide is running, both result registers can be loaded directly from a write port.

Top module: `bg_divider`

## Requirements
- R1: After reset both result registers are 0, both flags are 0, and busy and stall are low.
- R2: A start seen while busy is low is accepted at that clock edge. For the next three cycles busy and stall are both high, whatever the other inputs are, so the divide holds the issue slot for four cycles in total.
- R3: At the edge that ends the fourth issue cycle, both flags are updated. The overflow flag is set when the divisor is 0 or when the upper 16 dividend bits are at least the divisor. The zero flag is set when there is no overflow and the dividend is below the divisor. The flags do not change during the background phase.
- R4: A divide without overflow keeps busy high for 17 further cycles. Its results are committed at the edge that ends the last of those cycles, and busy is low from the 21st cycle after acceptance onward.
- R5: The committed low result register holds the unsigned quotient and the high result register holds the remainder.
- R6: An overflowing divide leaves both result registers unchanged and skips the background phase. Busy is low in the cycle that follows the issue cycles.
- R7: During the background phase, stall is high in exactly those cycles in which a read, a write or a start is requested. A read issued straight after the issue cycles is therefore stalled for 17 cycles, then proceeds with stall low.
- R8: While busy is low, a write request loads the write data into the chosen result register at the next edge. A write requested while busy is high has no effect.
- R9: A start requested while busy is high is ignored. The running divide finishes with its own results and flags.
- R10: The flags keep their values until the issue phase of the next accepted divide ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Divide command |
| dividend | input | 32 | Unsigned dividend, sampled when the start is accepted |
| divisor | input | 16 | Unsigned divisor, sampled when the start is accepted |
| rd_lo | input | 1 | Read request, low result register |
| rd_hi | input | 1 | Read request, high result register |
| wr_lo | input | 1 | Write request, low result register |
| wr_hi | input | 1 | Write request, high result register |
| wr_data | input | 16 | Data for a result-register write |
| res_lo | output | 16 | Low result register (quotient) |
| res_hi | output | 16 | High result register (remainder) |
| flag_ovf | output | 1 | Overflow flag |
| flag_zero | output | 1 | Zero-quotient flag |
| busy | output | 1 | A divide is in its issue or background phase |
| stall | output | 1 | Stall request for the requesting instruction |

## Verification
A wrong phase or cycle count shows up first on busy and stall. If the issue window or the background window is off by even one cycle, the release of a read held since the first background cycle lands on the wrong cycle, so the count of stalled cycles differs from 17. A wrong step in the shift-and-subtract sequence stays hidden until the commit edge. At that edge it appears in the quotient or the remainder, so every divide compares both registers against arithmetic computed in the bench. A lost guard on writes or starts during the background phase changes a result register in the very next cycle, or corrupts the committed results, and both are compared.

// File: rtl/bg_divider.sv
module bg_divider #(
  parameter int W         = 16,
  parameter int ISSUE_CYC = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  input  logic           rd_lo,
  input  logic           rd_hi,
  input  logic           wr_lo,
  input  logic           wr_hi,
  input  logic [W-1:0]   wr_data,
  output logic [W-1:0]   res_lo,
  output logic [W-1:0]   res_hi,
  output logic           flag_ovf,
  output logic           flag_zero,
  output logic           busy,
  output logic           stall
);
  localparam int BG_CYC = W + 1;
  localparam int CW     = $clog2(BG_CYC + ISSUE_CYC) + 1;

  typedef enum logic [1:0] {IDLE, ISSUE, BACK} phase_t;

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic [W-1:0]  part, qsh, den;

  logic          req, ovf_now, zero_now, ge;
  logic [W:0]    shifted;
  logic [W+1:0]  diff;

  assign req      = rd_lo | rd_hi | wr_lo | wr_hi | start;
  assign busy     = (phase != IDLE);
  assign stall    = (phase == ISSUE) || ((phase == BACK) && req);

  assign ovf_now  = (den == '0) || (part >= den);
  assign zero_now = !ovf_now && (part == '0) && (qsh < den);

  assign shifted  = {part, qsh[W-1]};
  assign diff     = {1'b0, shifted} - {2'b00, den};
  assign ge       = !diff[W+1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= IDLE;
      cnt       <= '0;
      part      <= '0;
      qsh       <= '0;
      den       <= '0;
      res_lo    <= '0;
      res_hi    <= '0;
      flag_ovf  <= 1'b0;
      flag_zero <= 1'b0;
    end else begin
      case (phase)
        IDLE: begin
          if (wr_lo) res_lo <= wr_data;
          if (wr_hi) res_hi <= wr_data;
          if (start) begin
            part  <= dividend[2*W-1:W];
            qsh   <= dividend[W-1:0];
            den   <= divisor;
            cnt   <= '0;
            phase <= ISSUE;
          end
        end
        ISSUE: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(ISSUE_CYC - 2)) begin
            flag_ovf  <= ovf_now;
            flag_zero <= zero_now;
            cnt       <= '0;
            phase     <= ovf_now ? IDLE : BACK;
          end
        end
        BACK: begin
          cnt <= cnt + 1'b1;
          if (cnt < CW'(W)) begin
            part <= ge ? diff[W-1:0] : shifted[W-1:0];
            qsh  <= {qsh[W-2:0], ge};
          end else begin
            res_lo <= qsh;
            res_hi <= part;
            phase  <= IDLE;
          end
        end
        default: phase <= IDLE;
      endcase
    end
  end

  assert_issue_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && stall));

  assert_flags_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == BACK && $past(phase) == BACK) |-> $stable({flag_ovf, flag_zero}));

  assert_idle_no_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !stall);

  assert_ovf_skips_bg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_ovf) |-> !busy);

  assert_results_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(res_lo) && $stable(res_hi)));
endmodule

// File: tb/bg_divider_test.sv
module bg_divider_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, rd_lo = 1'b0, rd_hi = 1'b0, wr_lo = 1'b0, wr_hi = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0, wr_data = '0;
  logic [15:0] res_lo, res_hi;
  logic        flag_ovf, flag_zero, busy, stall;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [15:0] m_lo = '0, m_hi = '0;
  logic        m_ovf = 0, m_zero = 0;

  always #10 clk = ~clk;

  bg_divider uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .res_lo(res_lo), .res_hi(res_hi), .flag_ovf(flag_ovf), .flag_zero(flag_zero),
    .busy(busy), .stall(stall));

  function automatic bit f_ovf(input logic [31:0] a, input logic [15:0] b);
    return (b == 0) || (a[31:16] >= b);
  endfunction

  function automatic logic [15:0] f_quo(input logic [31:0] a, input logic [15:0] b);
    logic [31:0] q = a / {16'h0, b};
    return q[15:0];
  endfunction

  function automatic logic [15:0] f_rem(input logic [31:0] a, input logic [15:0] b);
    logic [31:0] r = a % {16'h0, b};
    return r[15:0];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #5;
  endtask

  task automatic run_div(input logic [31:0] a, input logic [15:0] b, input int probe);
    bit ovf = f_ovf(a, b);
    start = 1; dividend = a; divisor = b;
    #1;
    chk(!stall && !busy, "R2", "accept cycle stall/busy", {stall, busy}, 0);
    tick;
    start = 0;
    for (int i = 1; i <= 3; i++) begin
      rd_lo = 1;
      #1;
      chk(stall && busy, "R2", "issue hold", {stall, busy}, 3);
      rd_lo = 0;
      tick;
    end
    m_ovf  = ovf;
    m_zero = !ovf && (a < {16'h0, b});
    #1;
    chk(flag_ovf == m_ovf, "R3", "overflow flag", flag_ovf, m_ovf);
    chk(flag_zero == m_zero, "R3", "zero flag", flag_zero, m_zero);
    if (ovf) begin
      chk(!busy, "R6", "busy after overflow issue", busy, 0);
      chk(res_lo == m_lo && res_hi == m_hi, "R6", "results unchanged",
          {res_hi, res_lo}, {m_hi, m_lo});
      return;
    end
    for (int c = 4; c <= 20; c++) begin
      bit any;
      if (probe == 1) rd_lo = 1;
      if (probe == 0) rd_hi = 1'($urandom % 2);
      if (probe == 2 && c == 5) begin wr_hi = 1; wr_data = 16'hA5C3; end
      if (probe == 3 && c >= 6 && c <= 8) begin
        start = 1; dividend = 32'h0000_0010; divisor = 16'h0003;
      end
      any = rd_lo | rd_hi | wr_hi | start;
      #1;
      chk(busy, "R4", "busy in background", busy, 1);
      chk(stall == any, "R7", "stall follows request", stall, any);
      if (probe == 2 && c == 6)
        chk(res_hi == m_hi, "R8", "write while busy ignored", res_hi, m_hi);
      tick;
      rd_hi = 0; wr_hi = 0; start = 0;
    end
    m_lo = f_quo(a, b);
    m_hi = f_rem(a, b);
    #1;
    chk(!busy, "R4", "busy low after 17 cycles", busy, 0);
    chk(!stall, "R7", "held read released", stall, 0);
    chk(res_lo == m_lo, (probe == 3) ? "R9" : "R5", "quotient", res_lo, m_lo);
    chk(res_hi == m_hi, (probe == 3) ? "R9" : "R5", "remainder", res_hi, m_hi);
    chk(flag_ovf == m_ovf && flag_zero == m_zero, "R10", "flags kept",
        {flag_ovf, flag_zero}, {m_ovf, m_zero});
    rd_lo = 0;
  endtask

  initial begin
    void'($urandom(32'd7));
    tick; tick;
    #1;
    chk(res_lo == 0 && res_hi == 0, "R1", "reset results", {res_hi, res_lo}, 0);
    chk(!flag_ovf && !flag_zero && !busy && !stall, "R1", "reset controls",
        {flag_ovf, flag_zero, busy, stall}, 0);
    rst_n = 1;
    tick;

    wr_lo = 1; wr_data = 16'h1234; tick; wr_lo = 0;
    #1; chk(res_lo == 16'h1234 && res_hi == 0, "R8", "idle write low", {res_hi, res_lo}, 32'h1234);
    m_lo = 16'h1234;
    wr_hi = 1; wr_data = 16'hBEEF; tick; wr_hi = 0;
    #1; chk(res_hi == 16'hBEEF, "R8", "idle write high", res_hi, 16'hBEEF);
    m_hi = 16'hBEEF;

    run_div(32'h0001_0000, 16'h0000, 0);
    run_div(32'h0005_0000, 16'h0005, 2);
    run_div(32'h0000_0004, 16'h0009, 1);
    run_div(32'hFFFE_FFFF, 16'hFFFF, 1);
    run_div(32'h0003_0007, 16'h0010, 3);
    run_div(32'h0000_0000, 16'h0001, 0);
    run_div(32'h0000_FFFF, 16'h0001, 2);

    for (int i = 0; i < 40; i++) begin
      logic [15:0] b = 16'($urandom);
      logic [31:0] a = $urandom;
      if (i % 5 != 0) begin
        if (b == 0) b = 16'd1;
        a[31:16] = 16'($urandom % {16'h0, b});
      end
      run_div(a, b, i % 4);
      tick;
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule